// File: doc/BRIEF.md
# Low-Power Sensor Acquisition Sequencer

This block runs one acquisition of one of five sensors on behalf of the digital core of a passive tag. The core presents a 3-bit sensor address, a 4-bit gain code and an 8-bit offset code for the conditioning stage, and a command bit that selects a read or a clear. On accept the block powers only the addressed sensor and closes its ground switch and output gate. For a read it enables the small measuring bias, waits a settling interval of fixed length, then triggers the ADC controller. It removes sensor power the moment the ADC reports that sampling has ended, and it returns the conversion result to the core.

A clear command drives a short high-current pulse into the selected external gas sensor to burn off contamination. The pulse length is a parameter counted in clock cycles. A clear never starts a conversion. Addresses with no sensor behind them complete at once with an error flag. A clear aimed at the internal temperature sensor completes the same way, because that sensor has no clear line. At the default parameters the whole sequence uses a few dozen cycles, far inside a reply window of roughly 309 µs.

Top module: `sensor_acq_seq`

## Requirements
- R1: After reset, busy_o, result_valid_o, error_o, adc_start_o, read_bias_o, clear_bias_o, temp_en_o, gnd_sw_o, out_gate_o, gain_o, offset_o and result_o are all zero.
- R2: A read of address 0 to 3 sets bit `addr` of both gnd_sw_o and out_gate_o, and no other bit of either, for the whole settle and sample phases. During those phases temp_en_o stays low.
- R3: A read of address 4 holds temp_en_o high during settle and sample. During that read gnd_sw_o, out_gate_o and read_bias_o stay zero.
- R4: A command to address 5, 6 or 7 drives result_valid_o and error_o high for the single cycle after the accept edge. busy_o stays low, and no switch or bias output is asserted.
- R5: A read of address 0 to 3 holds read_bias_o high from the cycle after accept. adc_start_o is high for exactly one cycle, which follows SETTLE_CYC cycles of settling.
- R6: In the cycle after adc_sample_done_i is seen during sampling, gnd_sw_o, out_gate_o, temp_en_o and read_bias_o are all zero, and busy_o is still high.
- R7: In the cycle after adc_done_i is seen during conversion, result_valid_o is high for one cycle and result_o equals the adc_data_i value captured at that edge. In that same cycle error_o and busy_o are low.
- R8: A clear of address 0 to 3 holds clear_bias_o and busy_o high for exactly CLEAR_CYC cycles, with the selected sensor's switches closed. It never asserts adc_start_o or result_valid_o.
- R9: A clear of address 4 completes like R4: result_valid_o and error_o are high for one cycle, and no bias or switch is asserted.
- R10: read_bias_o and clear_bias_o are never high in the same cycle.
- R11: A command presented while busy_o is high is ignored. gain_o, offset_o and the selected switches stay unchanged.
- R12: gain_o and offset_o take the gain and offset codes of an accepted valid command from the cycle after accept, and hold them until the next accepted valid command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request from the core |
| cmd_clear_i | input | 1 | 1 = clear pulse, 0 = read |
| cmd_addr_i | input | 3 | Sensor address (0-3 gas, 4 temperature) |
| cmd_gain_i | input | 4 | Gain code for the conditioning stage |
| cmd_offset_i | input | 8 | Offset code for the conditioning stage |
| busy_o | output | 1 | Sequence in progress |
| gnd_sw_o | output | 4 | Ground switch enable per gas sensor |
| out_gate_o | output | 4 | Output transmission gate enable per gas sensor |
| temp_en_o | output | 1 | Temperature sensor power |
| read_bias_o | output | 1 | Measuring bias enable |
| clear_bias_o | output | 1 | Clearing pulse enable |
| gain_o | output | 4 | Gain code to the conditioning stage |
| offset_o | output | 8 | Offset code to the conditioning stage |
| adc_start_o | output | 1 | One-cycle conversion trigger |
| adc_sample_done_i | input | 1 | ADC reports end of sample-and-hold |
| adc_done_i | input | 1 | ADC reports conversion complete |
| adc_data_i | input | 8 | ADC result |
| result_valid_o | output | 1 | Result or error completion strobe |
| error_o | output | 1 | Completion was a rejected command |
| result_o | output | 8 | Last conversion result |

## Verification
The hardest condition to reach is a second command arriving while a read or clear is running. That command must change neither the conditioning codes nor the switches. The stimulus injects a conflicting command partway through each settle window and each clear pulse. The ADC model varies the delays to sample-done and conversion-done, so that power removal is tested at a different cycle each time. Error completions are mixed in between valid sequences, which shows that a rejected command neither disturbs the held codes nor asserts busy.

// File: rtl/sensor_acq_pkg.sv
package sensor_acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_CONVERT,
    ST_CLEAR
  } acq_state_e;
endpackage

// File: rtl/sensor_sel_decode.sv
module sensor_sel_decode #(
  parameter int N_EXT  = 4,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_EXT-1:0]  ext_o,
  output logic              temp_o,
  output logic              bad_o
);
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign ext_o[g] = (addr_i == ADDR_W'(g));
  end
  assign temp_o = (addr_i == ADDR_W'(N_EXT));
  assign bad_o  = (addr_i >  ADDR_W'(N_EXT));
endmodule

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import sensor_acq_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int CLEAR_CYC  = 24,
  parameter int CNT_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_clear_i,
  input  logic             bad_addr_i,
  input  logic             temp_addr_i,
  input  logic             timer_zero_i,
  input  logic             sample_done_i,
  input  logic             conv_done_i,
  output logic             accept_o,
  output logic             reject_o,
  output logic             timer_load_o,
  output logic [CNT_W-1:0] timer_val_o,
  output logic             start_o,
  output logic             capture_o,
  output acq_state_e       state_o
);
  acq_state_e state_q;
  logic       start_q;
  logic       cmd_err;

  // clear has no line on the temperature sensor
  assign cmd_err      = bad_addr_i | (cmd_clear_i & temp_addr_i);
  assign accept_o     = (state_q == ST_IDLE) & cmd_valid_i & ~cmd_err;
  assign reject_o     = (state_q == ST_IDLE) & cmd_valid_i &  cmd_err;
  assign timer_load_o = accept_o;
  assign timer_val_o  = cmd_clear_i ? CNT_W'(CLEAR_CYC - 1) : CNT_W'(SETTLE_CYC - 1);
  assign capture_o    = (state_q == ST_CONVERT) & conv_done_i;
  assign start_o      = start_q;
  assign state_o      = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) state_q <= cmd_clear_i ? ST_CLEAR : ST_SETTLE;
        end
        ST_SETTLE: begin
          if (timer_zero_i) begin
            state_q <= ST_SAMPLE;
            start_q <= 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (sample_done_i) state_q <= ST_CONVERT;
        end
        ST_CONVERT: begin
          if (conv_done_i) state_q <= ST_IDLE;
        end
        ST_CLEAR: begin
          if (timer_zero_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sensor_acq_seq.sv
module sensor_acq_seq
  import sensor_acq_pkg::*;
#(
  parameter int N_EXT      = 4,
  parameter int ADDR_W     = 3,
  parameter int GAIN_W     = 4,
  parameter int OFS_W      = 8,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 16,
  parameter int CLEAR_CYC  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_clear_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [GAIN_W-1:0] cmd_gain_i,
  input  logic [OFS_W-1:0]  cmd_offset_i,
  output logic              busy_o,
  output logic [N_EXT-1:0]  gnd_sw_o,
  output logic [N_EXT-1:0]  out_gate_o,
  output logic              temp_en_o,
  output logic              read_bias_o,
  output logic              clear_bias_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [OFS_W-1:0]  offset_o,
  output logic              adc_start_o,
  input  logic              adc_sample_done_i,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              result_valid_o,
  output logic              error_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int MAX_CYC = (SETTLE_CYC > CLEAR_CYC) ? SETTLE_CYC : CLEAR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [N_EXT-1:0]  dec_ext;
  logic              dec_temp, dec_bad;
  logic              accept, reject, capture;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  acq_state_e        state_q;

  logic [N_EXT:0]    sel_q;
  logic [GAIN_W-1:0] gain_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              valid_q, err_q;
  logic [DATA_W-1:0] res_q;
  logic              sense_ph, pwr_ph;

  sensor_sel_decode #(.N_EXT(N_EXT), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (cmd_addr_i),
    .ext_o  (dec_ext),
    .temp_o (dec_temp),
    .bad_o  (dec_bad)
  );

  acq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  acq_fsm #(.SETTLE_CYC(SETTLE_CYC), .CLEAR_CYC(CLEAR_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_clear_i   (cmd_clear_i),
    .bad_addr_i    (dec_bad),
    .temp_addr_i   (dec_temp),
    .timer_zero_i  (tmr_zero),
    .sample_done_i (adc_sample_done_i),
    .conv_done_i   (adc_done_i),
    .accept_o      (accept),
    .reject_o      (reject),
    .timer_load_o  (tmr_load),
    .timer_val_o   (tmr_val),
    .start_o       (adc_start_o),
    .capture_o     (capture),
    .state_o       (state_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      gain_q <= '0;
      ofs_q  <= '0;
    end else if (accept) begin
      sel_q  <= {dec_temp, dec_ext};
      gain_q <= cmd_gain_i;
      ofs_q  <= cmd_offset_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= reject | capture;
      err_q   <= reject;
      if (capture) res_q <= adc_data_i;
    end
  end

  // power held only until sample-and-hold ends
  assign sense_ph = (state_q == ST_SETTLE) | (state_q == ST_SAMPLE);
  assign pwr_ph   = sense_ph | (state_q == ST_CLEAR);

  assign gnd_sw_o       = pwr_ph ? sel_q[N_EXT-1:0] : '0;
  assign out_gate_o     = pwr_ph ? sel_q[N_EXT-1:0] : '0;
  assign temp_en_o      = sense_ph & sel_q[N_EXT];
  assign read_bias_o    = sense_ph & (|sel_q[N_EXT-1:0]);
  assign clear_bias_o   = (state_q == ST_CLEAR);
  assign busy_o         = (state_q != ST_IDLE);
  assign gain_o         = gain_q;
  assign offset_o       = ofs_q;
  assign result_valid_o = valid_q;
  assign error_o        = err_q;
  assign result_o       = res_q;
endmodule

// File: rtl/sensor_acq_checker.sv
module sensor_acq_checker
  import sensor_acq_pkg::*;
#(
  parameter int N_EXT  = 4,
  parameter int GAIN_W = 4,
  parameter int OFS_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input acq_state_e        state_q,
  input logic              busy_o,
  input logic [N_EXT-1:0]  gnd_sw_o,
  input logic [N_EXT-1:0]  out_gate_o,
  input logic              temp_en_o,
  input logic              read_bias_o,
  input logic              clear_bias_o,
  input logic              adc_start_o,
  input logic              adc_sample_done_i,
  input logic              result_valid_o,
  input logic              error_o,
  input logic [GAIN_W-1:0] gain_o,
  input logic [OFS_W-1:0]  offset_o
);
  a_r10_bias_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(read_bias_o && clear_bias_o));

  a_r2_single_sensor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gnd_sw_o, temp_en_o}));

  a_r8_no_start_in_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_bias_o |-> !adc_start_o);

  a_r5_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  a_r6_power_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAMPLE && adc_sample_done_i) |=>
      (gnd_sw_o == '0 && out_gate_o == '0 && !temp_en_o && !read_bias_o && busy_o));

  a_r4_error_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (result_valid_o && !busy_o && !read_bias_o && !clear_bias_o));

  a_r11_config_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(gain_o) && $stable(offset_o)));
endmodule

bind sensor_acq_seq sensor_acq_checker #(
  .N_EXT(N_EXT), .GAIN_W(GAIN_W), .OFS_W(OFS_W)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .state_q           (state_q),
  .busy_o            (busy_o),
  .gnd_sw_o          (gnd_sw_o),
  .out_gate_o        (out_gate_o),
  .temp_en_o         (temp_en_o),
  .read_bias_o       (read_bias_o),
  .clear_bias_o      (clear_bias_o),
  .adc_start_o       (adc_start_o),
  .adc_sample_done_i (adc_sample_done_i),
  .result_valid_o    (result_valid_o),
  .error_o           (error_o),
  .gain_o            (gain_o),
  .offset_o          (offset_o)
);

// File: tb/sensor_acq_seq_tb.sv
module sensor_acq_seq_tb_top;
  localparam int SETTLE = 16;
  localparam int CLR    = 24;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0, cmd_clear_i = 1'b0;
  logic [2:0] cmd_addr_i = '0;
  logic [3:0] cmd_gain_i = '0;
  logic [7:0] cmd_offset_i = '0;
  logic       adc_sample_done_i = 1'b0, adc_done_i = 1'b0;
  logic [7:0] adc_data_i = '0;
  logic       busy_o, temp_en_o, read_bias_o, clear_bias_o, adc_start_o;
  logic       result_valid_o, error_o;
  logic [3:0] gnd_sw_o, out_gate_o, gain_o;
  logic [7:0] offset_o, result_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [3:0] exp_gain = '0;
  logic [7:0] exp_ofs  = '0;

  always #2 clk_i = ~clk_i;

  sensor_acq_seq #(.SETTLE_CYC(SETTLE), .CLEAR_CYC(CLR)) dut_i (.*);

  function automatic logic [3:0] ext_sel(input logic [2:0] a);
    return (a < 3'd4) ? (4'b0001 << a) : 4'b0000;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_read(input logic [2:0] a, input logic [3:0] g, input logic [7:0] o,
                         input logic [7:0] d, input int sd, input int cv);
    cmd_valid_i = 1; cmd_clear_i = 0; cmd_addr_i = a; cmd_gain_i = g; cmd_offset_i = o;
    step();
    cmd_valid_i = 0;
    exp_gain = g; exp_ofs = o;
    for (int i = 0; i < SETTLE; i++) begin
      check(busy_o && !adc_start_o && !clear_bias_o, "R5 settle", {busy_o, adc_start_o}, 2);
      check(gnd_sw_o == ext_sel(a) && out_gate_o == ext_sel(a), "R2 switches",
            {gnd_sw_o, out_gate_o}, {ext_sel(a), ext_sel(a)});
      check(temp_en_o == (a == 3'd4), "R3 temp_en", temp_en_o, a == 3'd4);
      check(read_bias_o == (a < 3'd4), "R5 read_bias", read_bias_o, a < 3'd4);
      check(gain_o == exp_gain && offset_o == exp_ofs, "R11 R12 config",
            {gain_o, offset_o}, {exp_gain, exp_ofs});
      if (i == 1) begin
        cmd_valid_i = 1; cmd_clear_i = $urandom_range(0, 1); cmd_addr_i = ~a;
        cmd_gain_i = ~g; cmd_offset_i = ~o;
      end
      step();
      cmd_valid_i = 0;
    end
    for (int j = 0; j <= sd; j++) begin
      check(adc_start_o == (j == 0), "R5 start pulse", adc_start_o, j == 0);
      check(gnd_sw_o == ext_sel(a) && temp_en_o == (a == 3'd4), "R2 R3 sample power",
            gnd_sw_o, ext_sel(a));
      if (j == sd) adc_sample_done_i = 1;
      step();
      adc_sample_done_i = 0;
    end
    for (int k = 0; k <= cv; k++) begin
      check(busy_o && gnd_sw_o == 0 && out_gate_o == 0 && !temp_en_o && !read_bias_o,
            "R6 power off", {busy_o, gnd_sw_o, temp_en_o, read_bias_o}, 8'h80);
      if (k == cv) begin adc_done_i = 1; adc_data_i = d; end
      step();
      adc_done_i = 0; adc_data_i = ~d;
    end
    check(result_valid_o && !error_o && !busy_o, "R7 valid",
          {result_valid_o, error_o, busy_o}, 3'b100);
    check(result_o == d, "R7 data", result_o, d);
    step();
    check(!result_valid_o && result_o == d, "R7 pulse", result_valid_o, 0);
  endtask

  task automatic do_clear(input logic [2:0] a, input logic [3:0] g, input logic [7:0] o);
    cmd_valid_i = 1; cmd_clear_i = 1; cmd_addr_i = a; cmd_gain_i = g; cmd_offset_i = o;
    step();
    cmd_valid_i = 0;
    exp_gain = g; exp_ofs = o;
    for (int i = 0; i < CLR; i++) begin
      check(busy_o && clear_bias_o && !read_bias_o && !adc_start_o && !result_valid_o,
            "R8 R10 clear pulse", {busy_o, clear_bias_o, read_bias_o, adc_start_o}, 4'b1100);
      check(gnd_sw_o == ext_sel(a) && out_gate_o == ext_sel(a), "R8 switches",
            gnd_sw_o, ext_sel(a));
      check(gain_o == exp_gain && offset_o == exp_ofs, "R11 clear config", gain_o, exp_gain);
      if (i == 2) begin
        cmd_valid_i = 1; cmd_clear_i = 0; cmd_addr_i = 3'd4; cmd_gain_i = ~g; cmd_offset_i = ~o;
      end
      step();
      cmd_valid_i = 0;
    end
    check(!busy_o && !clear_bias_o && gnd_sw_o == 0 && !result_valid_o, "R8 clear end",
          {busy_o, clear_bias_o, gnd_sw_o}, 0);
    step();
    check(!result_valid_o && !adc_start_o && !busy_o, "R8 no result", result_valid_o, 0);
  endtask

  task automatic do_bad(input logic [2:0] a, input logic clr);
    cmd_valid_i = 1; cmd_clear_i = clr; cmd_addr_i = a; cmd_gain_i = 4'h5; cmd_offset_i = 8'h3c;
    check(!busy_o, "R4 no busy at accept", busy_o, 0);
    step();
    cmd_valid_i = 0;
    check(result_valid_o && error_o && !busy_o, "R4 R9 error strobe",
          {result_valid_o, error_o, busy_o}, 3'b110);
    check(gnd_sw_o == 0 && out_gate_o == 0 && !temp_en_o && !read_bias_o && !clear_bias_o,
          "R4 R9 no drive", {gnd_sw_o, temp_en_o, read_bias_o, clear_bias_o}, 0);
    check(gain_o == exp_gain && offset_o == exp_ofs, "R12 error keeps config", gain_o, exp_gain);
    step();
    check(!result_valid_o && !error_o && !busy_o, "R4 single cycle", {result_valid_o, error_o}, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk_i);
    check(busy_o == 0 && result_valid_o == 0 && error_o == 0 && adc_start_o == 0 &&
          read_bias_o == 0 && clear_bias_o == 0 && temp_en_o == 0 && gnd_sw_o == 0 &&
          out_gate_o == 0 && gain_o == 0 && offset_o == 0 && result_o == 0,
          "R1 reset", busy_o, 0);
    step();
    rst_ni = 1;
    step();
    // directed corner cases
    do_read(3'd0, 4'h3, 8'h11, 8'hA5, 0, 0);
    do_read(3'd3, 4'hF, 8'hFF, 8'h00, 3, 5);
    do_read(3'd4, 4'h1, 8'h80, 8'hFF, 1, 2);
    do_bad(3'd5, 1'b0);
    do_bad(3'd7, 1'b1);
    do_bad(3'd4, 1'b1);
    do_clear(3'd2, 4'h9, 8'h42);
    do_bad(3'd6, 1'b0);
    // random mix
    for (int n = 0; n < 40; n++) begin
      int kind = $urandom_range(0, 9);
      logic [2:0] a = 3'($urandom_range(0, 7));
      if (kind < 6 && a <= 3'd4)
        do_read(a, 4'($urandom), 8'($urandom), 8'($urandom),
                $urandom_range(0, 6), $urandom_range(0, 8));
      else if (kind < 8 && a < 3'd4)
        do_clear(a, 4'($urandom), 8'($urandom));
      else if (a > 3'd4)
        do_bad(a, 1'($urandom));
      else
        do_bad(3'd4, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule